// File: doc/BRIEF.md
# JTAG Register Bridge

This block gives a JTAG host access to a bank of eight 32-bit registers inside the chip. It sits behind a user data register of a TAP controller that lives outside the block. The controller supplies the capture, shift and update strobes, a select line, TDI and TCK. The bridge returns TDO.

Each scan moves a 36-bit command word: the top bit is a write flag, the next three bits are a register index, and the low 32 bits are a data value. When the update strobe arrives, the command crosses into the system clock domain. There it becomes a single write or read strobe on a small register bus. Results of reads are held in the system domain. The capture phase of a later scan loads the held result into the low 32 bits of the scan register, so a read costs two scans. Because bits enter at the top of the register, the first scan of a read can be cut to only four bits.

Top module: `jrb_bridge`

## Requirements
- R1: While rst_ni is low and after reset is released, tdo_o, bus_we_o and bus_re_o are 0, bus_addr_o, bus_wdata_o and bus_rdata_o are zero, and every bank register reads back as zero.
- R2: With sel_i and shift_i high, each rising TCK edge moves the scan register one place toward bit 0 and puts tdi_i into bit 35. tdo_o always shows bit 0, so bits leave least significant first.
- R3: An update whose bit 35 is 1 produces exactly one bus_we_o pulse. During that pulse bus_addr_o carries bits 34:32 and bus_wdata_o carries bits 31:0, and the addressed register takes that value.
- R4: An update whose bit 35 is 0 produces exactly one bus_re_o pulse at the address in bits 34:32. On the next system clock, bus_rdata_o holds that register's value. Bits 31:0 of a read command change no register.
- R5: With sel_i and capture_i high, a rising TCK edge loads bits 31:0 of the scan register from bus_rdata_o and clears bits 35:32.
- R6: A read can be issued by shifting only four bits before the update. Those four bits, taken least significant first, are the three address bits and then a 0 flag.
- R7: When sel_i is low, capture, shift and update have no effect. The scan register, tdo_o, the bus strobes and the bank all stay unchanged.
- R8: Every update gives exactly one bus strobe lasting one system clock, and bus_we_o and bus_re_o are never high together.
- R9: All eight registers can be addressed and hold their values independently of one another.
- R10: bus_rdata_o changes only on the clock that follows a bus_re_o pulse. Writes, including writes to the register last read, leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| tck_i | input | 1 | Test clock |
| sel_i | input | 1 | Bridge's user register is selected |
| capture_i | input | 1 | Capture-DR strobe, TCK domain |
| shift_i | input | 1 | Shift-DR strobe, TCK domain |
| update_i | input | 1 | Update-DR strobe, TCK domain |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (scan bit 0) |
| bus_we_o | output | 1 | One-cycle write strobe |
| bus_re_o | output | 1 | One-cycle read strobe |
| bus_addr_o | output | 3 | Register index of the last command |
| bus_wdata_o | output | 32 | Write data of the last command |
| bus_rdata_o | output | 32 | Held result of the last read |

## Verification
The assertions assume that TCK is much slower than the system clock, and that the host leaves enough time for the synchronizer and the bus stage to settle before it sends another update or captures. Under these conditions each toggle yields exactly one strobe, and the read result is stable whenever TCK samples it. The bench drives TCK from tasks with a period six times the system clock period. After each update it waits eight system clocks before it starts the next scan. It changes strobes only while TCK is low.

// File: rtl/jrb_pkg.sv
package jrb_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned HDR_W    = ADDR_W + 1;
  localparam int unsigned DR_W     = DATA_W + HDR_W;
  localparam int unsigned NUM_REGS = 1 << ADDR_W;

  // field order is the scan word layout: flag on top, data at bit 0
  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/jrb_scan.sv
module jrb_scan
  import jrb_pkg::*;
(
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              tdo_o,
  output cmd_t              cmd_o,
  output logic              req_tgl_o
);
  logic [DR_W-1:0] sr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (sel_i && capture_i) begin
      sr_q <= {{HDR_W{1'b0}}, rd_data_i};
    end else if (sel_i && shift_i) begin
      sr_q <= {tdi_i, sr_q[DR_W-1:1]};
    end
  end

  // command held here until the next update; system side samples it after sync
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o     <= '0;
      req_tgl_o <= 1'b0;
    end else if (sel_i && update_i) begin
      cmd_o     <= cmd_t'(sr_q);
      req_tgl_o <= ~req_tgl_o;
    end
  end

  assign tdo_o = sr_q[0];
endmodule

// File: rtl/jrb_cdc.sv
module jrb_cdc #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  localparam int unsigned TOT = SYNC_STAGES + 1;

  logic [TOT-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[TOT-2:0], tgl_i};
  end

  assign pulse_o = sync_q[TOT-1] ^ sync_q[TOT-2];
endmodule

// File: rtl/jrb_exec.sv
module jrb_exec
  import jrb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  cmd_t              cmd_i,
  output logic              we_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      re_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= pulse_i &  cmd_i.wr;
      re_o <= pulse_i & ~cmd_i.wr;
      if (pulse_i) begin
        addr_o <= cmd_i.addr;
        if (cmd_i.wr) wdata_o <= cmd_i.data;
      end
    end
  end
endmodule

// File: rtl/jrb_bank.sv
module jrb_bank
  import jrb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs_q[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g))   regs_q[g] <= wdata_i;
    end
  end

  // held result: crosses to TCK as a quasi-static value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= regs_q[addr_i];
  end
endmodule

// File: rtl/jrb_bridge.sv
module jrb_bridge
  import jrb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tck_i,
  input  logic        sel_i,
  input  logic        capture_i,
  input  logic        shift_i,
  input  logic        update_i,
  input  logic        tdi_i,
  output logic        tdo_o,
  output logic        bus_we_o,
  output logic        bus_re_o,
  output logic [2:0]  bus_addr_o,
  output logic [31:0] bus_wdata_o,
  output logic [31:0] bus_rdata_o
);
  cmd_t cmd;
  logic req_tgl;
  logic req_pulse;

  jrb_scan u_scan (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .capture_i (capture_i),
    .shift_i   (shift_i),
    .update_i  (update_i),
    .tdi_i     (tdi_i),
    .rd_data_i (bus_rdata_o),
    .tdo_o     (tdo_o),
    .cmd_o     (cmd),
    .req_tgl_o (req_tgl)
  );

  jrb_cdc #(.SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tgl_i   (req_tgl),
    .pulse_o (req_pulse)
  );

  jrb_exec u_exec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (req_pulse),
    .cmd_i   (cmd),
    .we_o    (bus_we_o),
    .re_o    (bus_re_o),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o)
  );

  jrb_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_o),
    .re_i    (bus_re_o),
    .addr_i  (bus_addr_o),
    .wdata_i (bus_wdata_o),
    .rdata_o (bus_rdata_o)
  );
endmodule

// File: rtl/jrb_bridge_chk.sv
module jrb_bridge_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tck_i,
  input logic        sel_i,
  input logic        capture_i,
  input logic        tdo_o,
  input logic        bus_we_o,
  input logic        bus_re_o,
  input logic [31:0] bus_rdata_o
);
  // R8
  we_re_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));

  // R8
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |=> !bus_we_o);

  // R8
  re_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_o |=> !bus_re_o);

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bus_rdata_o) |-> $past(bus_re_o));

  // R5
  capture_load_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_i && capture_i) |=> (tdo_o == $past(bus_rdata_o[0])));

  // R7
  nosel_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel_i |=> $stable(tdo_o));
endmodule

bind jrb_bridge jrb_bridge_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tck_i       (tck_i),
  .sel_i       (sel_i),
  .capture_i   (capture_i),
  .tdo_o       (tdo_o),
  .bus_we_o    (bus_we_o),
  .bus_re_o    (bus_re_o),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/jrb_bridge_tb.sv
module jrb_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TCK_HALF   = 30;

  logic        clk = 1'b0, rst_ni = 1'b0, tck = 1'b0;
  logic        sel = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
  logic        tdo, bus_we, bus_re;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int total = 0, bad = 0;
  int we_cnt = 0, re_cnt = 0;
  bit both_seen = 1'b0;
  logic [31:0] exp_q [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  jrb_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tck_i(tck), .sel_i(sel),
    .capture_i(capture), .shift_i(shift), .update_i(update), .tdi_i(tdi),
    .tdo_o(tdo), .bus_we_o(bus_we), .bus_re_o(bus_re),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_o(bus_rdata)
  );

  always @(negedge clk) if (rst_ni) begin
    if (bus_we) we_cnt++;
    if (bus_re) re_cnt++;
    if (bus_we && bus_re) both_seen = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tck_cycle();
    #TCK_HALF tck = 1'b1;
    #TCK_HALF tck = 1'b0;
  endtask

  task automatic scan(input logic [35:0] din, input int nbits, input bit do_cap,
                      input bit do_upd, input bit upd_sel, output logic [35:0] dout);
    dout = '0;
    sel  = 1'b1;
    if (do_cap) begin
      capture = 1'b1; tck_cycle(); capture = 1'b0;
    end
    shift = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      tdi = din[i];
      dout[i] = tdo;
      tck_cycle();
    end
    shift = 1'b0;
    if (do_upd) begin
      sel = upd_sel; update = 1'b1; tck_cycle(); update = 1'b0;
    end
    sel = 1'b0;
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    logic [35:0] x;
    scan({1'b1, a, d}, 36, 1'b0, 1'b1, 1'b1, x);
  endtask

  task automatic rd(input logic [2:0] a, output logic [35:0] v);
    logic [35:0] x;
    scan({1'b0, a, 32'hDEAD_BEEF}, 36, 1'b0, 1'b1, 1'b1, x);
    scan(36'h0, 36, 1'b1, 1'b0, 1'b0, v);
  endtask

  task automatic t_reset();
    logic [35:0] v;
    chk(tdo == 1'b0 && !bus_we && !bus_re, "R1 strobes/tdo", {33'b0, tdo, bus_we, bus_re}, 36'h0);
    chk(bus_addr == 0 && bus_wdata == 0 && bus_rdata == 0, "R1 bus", {1'b0, bus_addr, bus_wdata | bus_rdata}, 36'h0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 36'h0, "R1 bank zero", v, 36'h0);
    end
  endtask

  task automatic t_write_all();
    logic [35:0] v;
    int w0, r0;
    for (int a = 0; a < 8; a++) begin
      exp_q[a] = (32'h1111_1111 * (a + 1)) ^ 32'hA5A5_0000;
      w0 = we_cnt; r0 = re_cnt;
      wr(3'(a), exp_q[a]);
      chk(we_cnt == w0 + 1 && re_cnt == r0, "R8 one we per write", 36'(we_cnt - w0), 36'h1);
      chk(bus_addr == 3'(a), "R3 addr", 36'(bus_addr), 36'(a));
      chk(bus_wdata == exp_q[a], "R3 wdata", 36'(bus_wdata), 36'(exp_q[a]));
    end
    for (int a = 0; a < 8; a++) begin
      r0 = re_cnt;
      rd(3'(a), v);
      chk(re_cnt == r0 + 1, "R8 one re per read", 36'(re_cnt - r0), 36'h1);
      chk(bus_rdata == exp_q[a], "R4 rdata", 36'(bus_rdata), 36'(exp_q[a]));
      chk(v == {4'h0, exp_q[a]}, "R9 R5 readback", v, {4'h0, exp_q[a]});
    end
  endtask

  task automatic t_read_ignores_data();
    logic [35:0] v;
    rd(3'd3, v);
    rd(3'd3, v);
    chk(v[31:0] == exp_q[3], "R4 data ignored", v, {4'h0, exp_q[3]});
  endtask

  task automatic t_short_read();
    logic [35:0] v, x;
    rd(3'd2, v);
    scan(36'h6, 4, 1'b0, 1'b1, 1'b1, x);  // bits: A0..A2 = 6, flag 0
    chk(bus_rdata == exp_q[6], "R6 short read rdata", 36'(bus_rdata), 36'(exp_q[6]));
    scan(36'h0, 36, 1'b1, 1'b0, 1'b0, v);
    chk(v == {4'h0, exp_q[6]}, "R6 short read capture", v, {4'h0, exp_q[6]});
  endtask

  task automatic t_shift_order();
    logic [35:0] p, v, x;
    p = 36'h9_3C5A_0F1E;
    scan(p, 36, 1'b0, 1'b0, 1'b0, x);
    scan(36'h0, 36, 1'b0, 1'b0, 1'b0, v);
    chk(v == p, "R2 lsb-first loop", v, p);
    chk(tdo == 1'b0, "R2 tdo bit0 after zeros", 36'(tdo), 36'h0);
  endtask

  task automatic t_nosel();
    logic [35:0] p, v, x;
    int w0;
    w0 = we_cnt;
    scan({1'b1, 3'd0, 32'hFFFF_0000}, 36, 1'b0, 1'b1, 1'b0, x);
    chk(we_cnt == w0 && re_cnt >= 0, "R7 update w/o sel", 36'(we_cnt - w0), 36'h0);
    rd(3'd0, v);
    chk(v[31:0] == exp_q[0], "R7 bank unchanged", v, {4'h0, exp_q[0]});
    p = 36'h5_A5F0_3C96;
    scan(p, 36, 1'b0, 1'b0, 1'b0, x);
    sel = 1'b0; tdi = 1'b1; shift = 1'b1; capture = 1'b1; update = 1'b1;
    for (int i = 0; i < 6; i++) tck_cycle();
    shift = 1'b0; capture = 1'b0; update = 1'b0;
    chk(tdo == p[0], "R7 tdo held", 36'(tdo), 36'(p[0]));
    scan(36'h0, 36, 1'b0, 1'b0, 1'b0, v);
    chk(v == p, "R7 scan reg held", v, p);
  endtask

  task automatic t_rdata_hold();
    logic [35:0] v;
    rd(3'd1, v);
    wr(3'd1, 32'h0BAD_F00D);
    chk(bus_rdata == exp_q[1], "R10 rdata held over write", 36'(bus_rdata), 36'(exp_q[1]));
    exp_q[1] = 32'h0BAD_F00D;
    rd(3'd1, v);
    chk(v[31:0] == exp_q[1], "R10 R3 new value", v, {4'h0, exp_q[1]});
    chk(!both_seen, "R8 exclusive strobes", 36'(both_seen), 36'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(tdo == 1'b0 && !bus_we && !bus_re && bus_rdata == 0, "R1 in reset", {3'b0, tdo, bus_rdata}, 36'h0);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_write_all();
    t_read_ignores_data();
    t_short_read();
    t_shift_order();
    t_nosel();
    t_rdata_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule